// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit effective address to a physical address after a translation-cache miss by searching a hashed page table held in memory. A programmable table-base register supplies the table's origin and the width of its hash mask. A bank of sixteen segment registers supplies the virtual segment identifier (VSID) for each 256 MiB region of the effective space.

Each request walks up to two groups of eight 8-byte entries. The primary group is chosen by a hash of the VSID and page index. The secondary group uses the complement of that hash and requires the hash-select flag in the entry. On a match the walker reads the entry's second word and sets its referenced bit, plus its changed bit on stores. Except for debug accesses, it writes that word back, returns the physical address and offers a refill word for the translation cache. On a complete miss it records fault information for the data or instruction side.

Requests use a valid/busy/done handshake. Memory is reached through a single word port with a ready strobe. Words on that port carry the byte at the lowest address in bits 31:24, so no byte swapping takes place inside the walker.

Top module: `hpt_walker`

## Requirements
- R1: A write to the table-base register takes effect only when its mask field (bits 8:0) is a run of ones starting at bit 0 and its origin field (bits 31:16) shares no set bit with that mask. Any other write leaves the previous base and hash mask in force. After reset the origin is 0 and the mask is 0.
- R2: The table base is origin << 16 and the hash mask is (mask << 10) | 0x3FF. An entry's first word lies at ((hash & hash mask) << 6) | base + 8 × slot, and its second word lies 4 bytes after the first. Every memory address is word aligned.
- R3: The segment register is picked by effective-address bits 31:28, and only its bits 23:0 (the VSID) take part in the walk.
- R4: An entry matches when its first word equals bit31 | VSID << 7 | H << 6 | API. API is effective-address bits 27:22, and H is 0 in the primary group and 1 in the secondary group.
- R5: The primary hash is VSID XOR page index, where the page index is effective-address bits 27:12. Slots 0 to 7 are read in order at 8-byte steps, first in the primary group and then in the secondary group, which uses the bitwise NOT of the hash. Scanning stops at the first match.
- R6: Access kind is encoded on req_kind as 0 debug, 1 load, 2 store and 3 fetch. On a match, loads and fetches write the second word back with bit 8 (R) set. Stores write it back with bits 8 and 7 (R and C) set. Debug accesses read the entry but write nothing.
- R7: On a match, pa equals second-word bits 31:12 followed by effective-address bits 11:0, and fault is low while done is high.
- R8: When a load or store misses both groups, fault_status becomes 0x40000000 for a load and 0x42000000 for a store, and fault_addr becomes the effective address. A debug miss changes neither register.
- R9: When a fetch misses both groups, next_pc becomes the effective address and fault_status is left unchanged.
- R10: fill_valid rises together with done on a matching load, store or fetch. fill_pte then carries the written-back second word. fill_valid stays low for debug accesses, for misses, and for requests flagged req_conly (walks made only to record a changed bit).
- R11: After reset busy, done and mem_req are low and the fault registers are zero. busy stays high from the cycle after an accepted request until done. done is high for exactly one cycle. No memory access is issued while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Write strobe for the table-base register |
| base_wdata | input | 32 | New table-base value (origin 31:16, mask 8:0) |
| seg_we | input | 1 | Write strobe for a segment register |
| seg_sel | input | 4 | Segment register index |
| seg_wdata | input | 32 | Segment register value (VSID in 23:0) |
| req_valid | input | 1 | Start a walk; sampled while idle |
| req_ea | input | 32 | Effective address to translate |
| req_kind | input | 2 | Access kind: 0 debug, 1 load, 2 store, 3 fetch |
| req_conly | input | 1 | Walk only to record a changed bit; suppresses refill |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | With done: no entry matched |
| pa | output | 32 | Physical address of the last hit |
| fill_valid | output | 1 | Refill offer for the translation cache |
| fill_pte | output | 32 | Second word as written back |
| fault_status | output | 32 | Data fault status |
| fault_addr | output | 32 | Data fault effective address |
| next_pc | output | 32 | Instruction fault resume address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory access completes this cycle |

## Verification
The bench builds the walker with its default eight slots per group and four segment-select bits, so a full miss costs sixteen entry reads and each step of the scan order can be counted. The table-base configurations run from a zero mask to a two-bit mask and the full nine-bit mask. These place group addresses from bit 16 up to bit 24 and show that a rejected register write leaves the earlier group address in use. Hits at slot 0, at slot 5 and in the secondary group run against a memory that answers every other cycle, and pin down the read counts and the written-back words.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam int HPT_AW     = 32;
  localparam int HPT_VSID_W = 24;
  localparam int HPT_MASK_W = 9;

  typedef enum logic [1:0] {
    ACC_DEBUG = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_FETCH = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_SCAN,
    WS_PTE2,
    WS_STORE,
    WS_DONE
  } walk_state_e;

  localparam logic [31:0] FS_PAGE  = 32'h4000_0000;
  localparam logic [31:0] FS_STORE = 32'h0200_0000;

  // Mask field is a run of ones anchored at bit 0 (zero allowed).
  function automatic logic mask_is_run(input logic [HPT_MASK_W-1:0] m);
    return ((m & (m + 1'b1)) == '0);
  endfunction

  // Origin may not set any bit that the mask also covers.
  function automatic logic base_ok(input logic [31:0] w);
    return mask_is_run(w[HPT_MASK_W-1:0]) &&
           ((w[16 +: HPT_MASK_W] & w[HPT_MASK_W-1:0]) == '0);
  endfunction

  function automatic logic [31:0] table_base(input logic [31:0] w);
    return {w[31:16], 16'h0000};
  endfunction

  function automatic logic [31:0] hash_mask(input logic [31:0] w);
    return {{(32-HPT_MASK_W-10){1'b0}}, w[HPT_MASK_W-1:0], 10'h3FF};
  endfunction

  function automatic logic [15:0] page_index(input logic [31:0] ea);
    return ea[27:12];
  endfunction

  function automatic logic [5:0] abbrev_index(input logic [31:0] ea);
    return ea[27:22];
  endfunction

  function automatic logic [31:0] prim_hash(input logic [HPT_VSID_W-1:0] vsid,
                                            input logic [15:0] pidx);
    return {8'h00, vsid} ^ {16'h0000, pidx};
  endfunction

  function automatic logic [31:0] group_addr(input logic [31:0] hash,
                                             input logic [31:0] hmask,
                                             input logic [31:0] base);
    return ((hash & hmask) << 6) | base;
  endfunction

  function automatic logic [31:0] cmp_word(input logic [HPT_VSID_W-1:0] vsid,
                                           input logic h,
                                           input logic [5:0] api);
    return {1'b1, vsid, h, api};
  endfunction

  function automatic logic [31:0] mark_access(input logic [31:0] pte2,
                                              input acc_kind_e kind);
    logic [31:0] r;
    r = pte2;
    if (kind != ACC_DEBUG) r[8] = 1'b1;
    if (kind == ACC_STORE) r[7] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] phys_addr(input logic [31:0] pte2,
                                            input logic [31:0] ea);
    return {pte2[31:12], ea[11:0]};
  endfunction

endpackage

// File: rtl/hpt_base_reg.sv
module hpt_base_reg
  import hpt_pkg::*;
#(
  parameter int MASK_W = HPT_MASK_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] base,
  output logic [31:0] hmask,
  output logic        ev_accept
);
  localparam logic [31:0] HMASK_RST = 32'h0000_03FF;

  logic unused_mid;
  assign unused_mid = ^wdata[15:MASK_W];

  assign ev_accept = we && base_ok(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      hmask <= HMASK_RST;
    end else if (ev_accept) begin
      base  <= table_base(wdata);
      hmask <= hash_mask(wdata);
    end
  end
endmodule

// File: rtl/hpt_seg_file.sv
module hpt_seg_file
  import hpt_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int VSID_W = HPT_VSID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEG_W-1:0]  wsel,
  input  logic [31:0]       wdata,
  input  logic [SEG_W-1:0]  rsel,
  output logic [VSID_W-1:0] vsid
);
  localparam int NUM_SEGS = 1 << SEG_W;

  logic [VSID_W-1:0] seg_q [NUM_SEGS];
  logic unused_flags;
  assign unused_flags = ^wdata[31:VSID_W];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        seg_q[g] <= '0;
      else if (we && (wsel == SEG_W'(g)))
        seg_q[g] <= wdata[VSID_W-1:0];
    end
  end

  assign vsid = seg_q[rsel];
endmodule

// File: rtl/hpt_group_gen.sv
module hpt_group_gen
  import hpt_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int ENTRY_BYTES = 8,
  parameter int VSID_W      = HPT_VSID_W
) (
  input  logic [VSID_W-1:0]        vsid,
  input  logic [31:0]              ea,
  input  logic                     hsel,
  input  logic [$clog2(SLOTS)-1:0] slot,
  input  logic [31:0]              base,
  input  logic [31:0]              hmask,
  output logic [31:0]              entry_addr,
  output logic [31:0]              cmp_w
);
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int ENTRY_SH  = $clog2(ENTRY_BYTES);

  logic [31:0] hash_p, hash_sel, grp;

  assign hash_p     = prim_hash(vsid, page_index(ea));
  assign hash_sel   = hsel ? ~hash_p : hash_p;
  assign grp        = group_addr(hash_sel, hmask, base);
  assign entry_addr = grp | (32'(slot) << ENTRY_SH);
  assign cmp_w      = cmp_word(vsid, hsel, abbrev_index(ea));

  logic unused_sw;
  assign unused_sw = (SLOT_W == 0);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SEG_W  = 4,
  parameter int VSID_W = HPT_VSID_W,
  parameter int MASK_W = HPT_MASK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [31:0]      base_wdata,
  input  logic             seg_we,
  input  logic [SEG_W-1:0] seg_sel,
  input  logic [31:0]      seg_wdata,
  input  logic             req_valid,
  input  logic [31:0]      req_ea,
  input  logic [1:0]       req_kind,
  input  logic             req_conly,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [31:0]      pa,
  output logic             fill_valid,
  output logic [31:0]      fill_pte,
  output logic [31:0]      fault_status,
  output logic [31:0]      fault_addr,
  output logic [31:0]      next_pc,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ready
);
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int ENTRY_BYTES = 8;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [31:0] WORD2_OFS = 32'd4;

  walk_state_e       state_q;
  logic [31:0]       ea_q, pte2_q, pa_q, fstat_q, faddr_q, npc_q;
  acc_kind_e         kind_q;
  logic              conly_q, hsel_q, fault_q;
  logic [VSID_W-1:0] vsid_q, rd_vsid;
  logic [SLOT_W-1:0] slot_q;
  logic [31:0]       tbl_base, tbl_hmask, entry_addr, cmp_w;

  // Named events for the checker.
  logic ev_base_accept, ev_match, ev_next_slot, ev_next_hash, ev_miss;
  logic ev_pte_read, ev_wb_done;

  hpt_base_reg #(.MASK_W(MASK_W)) u_base (
    .clk(clk), .rst_n(rst_n), .we(base_we), .wdata(base_wdata),
    .base(tbl_base), .hmask(tbl_hmask), .ev_accept(ev_base_accept)
  );

  hpt_seg_file #(.SEG_W(SEG_W), .VSID_W(VSID_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .we(seg_we), .wsel(seg_sel), .wdata(seg_wdata),
    .rsel(req_ea[31 -: SEG_W]), .vsid(rd_vsid)
  );

  hpt_group_gen #(.SLOTS(SLOTS), .ENTRY_BYTES(ENTRY_BYTES), .VSID_W(VSID_W)) u_grp (
    .vsid(vsid_q), .ea(ea_q), .hsel(hsel_q), .slot(slot_q),
    .base(tbl_base), .hmask(tbl_hmask),
    .entry_addr(entry_addr), .cmp_w(cmp_w)
  );

  logic scan_rsp, last_slot;
  assign scan_rsp     = (state_q == WS_SCAN) && mem_ready;
  assign last_slot    = (slot_q == LAST_SLOT);
  assign ev_match     = scan_rsp && (mem_rdata == cmp_w);
  assign ev_next_slot = scan_rsp && !ev_match && !last_slot;
  assign ev_next_hash = scan_rsp && !ev_match && last_slot && !hsel_q;
  assign ev_miss      = scan_rsp && !ev_match && last_slot && hsel_q;
  assign ev_pte_read  = (state_q == WS_PTE2) && mem_ready;
  assign ev_wb_done   = (state_q == WS_STORE) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      ea_q    <= '0;
      kind_q  <= ACC_DEBUG;
      conly_q <= 1'b0;
      vsid_q  <= '0;
      hsel_q  <= 1'b0;
      slot_q  <= '0;
      pte2_q  <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      fstat_q <= '0;
      faddr_q <= '0;
      npc_q   <= '0;
    end else begin
      case (state_q)
        WS_IDLE: if (req_valid) begin
          ea_q    <= req_ea;
          kind_q  <= acc_kind_e'(req_kind);
          conly_q <= req_conly;
          vsid_q  <= rd_vsid;
          hsel_q  <= 1'b0;
          slot_q  <= '0;
          fault_q <= 1'b0;
          state_q <= WS_SCAN;
        end
        WS_SCAN: begin
          if (ev_match) begin
            state_q <= WS_PTE2;
          end else if (ev_next_slot) begin
            slot_q <= slot_q + 1'b1;
          end else if (ev_next_hash) begin
            hsel_q <= 1'b1;
            slot_q <= '0;
          end else if (ev_miss) begin
            fault_q <= 1'b1;
            state_q <= WS_DONE;
            case (kind_q)
              ACC_LOAD: begin
                fstat_q <= FS_PAGE;
                faddr_q <= ea_q;
              end
              ACC_STORE: begin
                fstat_q <= FS_PAGE | FS_STORE;
                faddr_q <= ea_q;
              end
              ACC_FETCH: npc_q <= ea_q;
              default: ;
            endcase
          end
        end
        WS_PTE2: if (ev_pte_read) begin
          pte2_q  <= mark_access(mem_rdata, kind_q);
          pa_q    <= phys_addr(mem_rdata, ea_q);
          state_q <= (kind_q == ACC_DEBUG) ? WS_DONE : WS_STORE;
        end
        WS_STORE: if (ev_wb_done) state_q <= WS_DONE;
        WS_DONE: state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != WS_IDLE);
  assign done         = (state_q == WS_DONE);
  assign fault        = done && fault_q;
  assign pa           = pa_q;
  assign fill_valid   = done && !fault_q && !conly_q && (kind_q != ACC_DEBUG);
  assign fill_pte     = pte2_q;
  assign fault_status = fstat_q;
  assign fault_addr   = faddr_q;
  assign next_pc      = npc_q;

  assign mem_req   = (state_q == WS_SCAN) || (state_q == WS_PTE2) || (state_q == WS_STORE);
  assign mem_we    = (state_q == WS_STORE);
  assign mem_addr  = (state_q == WS_SCAN) ? entry_addr : (entry_addr | WORD2_OFS);
  assign mem_wdata = pte2_q;
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic        fill_valid,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        wb_ref_bit,
  input logic [31:0] fault_status,
  input logic [31:0] next_pc,
  input logic        ev_next_slot,
  input logic        ev_next_hash
);
  // R11: completion strobe lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: no memory traffic or completion while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  // R2: all memory addresses are word aligned
  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R5: next slot sits 8 bytes further on
  p_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_next_slot |=> (mem_addr == $past(mem_addr) + 32'd8));

  // R5: secondary scan restarts at slot 0 of a group
  p_rehash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_next_hash |=> (mem_addr[5:0] == 6'd0));

  // R6: every write-back carries the referenced bit
  p_wb_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> wb_ref_bit);

  // R10: refill only alongside a successful completion
  p_fill_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (done && !fault));

  // R8: status changes only as a fault completes
  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_status) |-> (done && fault));

  // R9: resume address changes only as a fault completes
  p_npc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(next_pc) |-> (done && fault));
endmodule

bind hpt_walker hpt_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .fill_valid(fill_valid), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .wb_ref_bit(mem_wdata[8]),
  .fault_status(fault_status), .next_pc(next_pc),
  .ev_next_slot(ev_next_slot), .ev_next_hash(ev_next_hash)
);

// File: tb/hpt_walker_tb_top.sv
`timescale 1ns/1ps
module hpt_walker_tb_top;
  localparam logic [1:0] K_DBG = 2'd0, K_LD = 2'd1, K_ST = 2'd2, K_IF = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic base_we = 0, seg_we = 0, req_valid = 0, req_conly = 0;
  logic [31:0] base_wdata = 0, seg_wdata = 0, req_ea = 0;
  logic [3:0] seg_sel = 0;
  logic [1:0] req_kind = 0;
  logic busy, done, fault, fill_valid, mem_req, mem_we, mem_ready;
  logic [31:0] pa, fill_pte, fault_status, fault_addr, next_pc;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hpt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .seg_we(seg_we), .seg_sel(seg_sel), .seg_wdata(seg_wdata),
    .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind), .req_conly(req_conly),
    .busy(busy), .done(done), .fault(fault), .pa(pa),
    .fill_valid(fill_valid), .fill_pte(fill_pte),
    .fault_status(fault_status), .fault_addr(fault_addr), .next_pc(next_pc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // Memory model: answers every other cycle.
  logic [31:0] mem [logic [31:0]];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_wr_addr = 0, last_wr_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      mem_rdata <= 32'h0;
    end else begin
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt++;
          last_wr_addr = mem_addr;
          last_wr_data = mem_wdata;
        end else begin
          rd_cnt++;
        end
      end
      mem_ready <= mem_req && !mem_ready;
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    end
  end

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Independent model of the table arithmetic.
  logic [31:0] m_base, m_hmask;

  function automatic logic [31:0] exp_group(input logic [23:0] vsid, input logic [31:0] ea,
                                            input bit second);
    logic [31:0] h;
    h = 32'(vsid) ^ ((ea >> 12) & 32'hFFFF);
    if (second) h = ~h;
    return ((h & m_hmask) * 32'd64) + m_base;
  endfunction

  function automatic logic [31:0] exp_cmp(input logic [23:0] vsid, input bit second,
                                          input logic [31:0] ea);
    return 32'h8000_0000 + (32'(vsid) << 7) + (second ? 32'd64 : 32'd0) + ((ea >> 22) & 32'h3F);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] w);
    @(negedge clk); base_we = 1; base_wdata = w;
    @(negedge clk); base_we = 0;
  endtask

  task automatic set_seg(input logic [3:0] i, input logic [31:0] w);
    @(negedge clk); seg_we = 1; seg_sel = i; seg_wdata = w;
    @(negedge clk); seg_we = 0;
  endtask

  logic [31:0] w_first, w_pa, w_fillpte;
  logic w_fault, w_fill, w_pulse_ok, w_busy;
  int w_reads, w_writes;

  task automatic walk(input logic [31:0] ea, input logic [1:0] kind, input bit conly);
    int r0, wr0, cyc;
    r0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk); req_valid = 1; req_ea = ea; req_kind = kind; req_conly = conly;
    @(negedge clk); req_valid = 0; w_first = mem_addr; w_busy = busy;
    cyc = 0;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    chk("R11 walk completes", {31'b0, done}, 32'd1);
    w_fault = fault; w_pa = pa; w_fill = fill_valid; w_fillpte = fill_pte;
    @(negedge clk); w_pulse_ok = !done;
    w_reads = rd_cnt - r0; w_writes = wr_cnt - wr0;
  endtask

  localparam logic [31:0] EA_A = 32'h3456_7ABC;
  localparam logic [23:0] VS3  = 24'h000123;
  localparam logic [23:0] VSB  = 24'h000ABC;

  task automatic t_reset();
    chk("R11 reset busy", {31'b0, busy}, 0);
    chk("R11 reset done", {31'b0, done}, 0);
    chk("R11 reset mem_req", {31'b0, mem_req}, 0);
    chk("R11 reset status", fault_status, 0);
    chk("R11 reset faddr", fault_addr, 0);
    chk("R11 reset npc", next_pc, 0);
  endtask

  task automatic t_primary_load();
    logic [31:0] g;
    mem.delete();
    g = exp_group(VS3, EA_A, 0);
    mem[g] = exp_cmp(VS3, 0, EA_A);
    mem[g + 4] = 32'hABCD_E012;
    walk(EA_A, K_LD, 0);
    chk("R11 busy after accept", {31'b0, w_busy}, 1);
    chk("R2 first read at primary slot0", w_first, g);
    chk("R7 load hit fault", {31'b0, w_fault}, 0);
    chk("R7 load hit pa", w_pa, 32'hABCD_EABC);
    chk("R6 load wb count", w_writes, 1);
    chk("R2 wb addr second word", last_wr_addr, g + 4);
    chk("R6 load sets R only", last_wr_data, 32'hABCD_E112);
    chk("R10 load fill", {31'b0, w_fill}, 1);
    chk("R10 fill word", w_fillpte, 32'hABCD_E112);
    chk("R5 reads for slot0 hit", w_reads, 2);
    chk("R11 done one cycle", {31'b0, w_pulse_ok}, 1);
  endtask

  task automatic t_store_slot5();
    logic [31:0] g, c;
    mem.delete();
    g = exp_group(VS3, EA_A, 0);
    c = exp_cmp(VS3, 0, EA_A);
    for (int i = 0; i < 5; i++) mem[g + 32'(i) * 8] = c ^ 32'h1;
    mem[g + 40] = c;
    mem[g + 44] = 32'h5555_5003;
    walk(EA_A, K_ST, 0);
    chk("R5 reads for slot5 hit", w_reads, 7);
    chk("R7 store hit pa", w_pa, 32'h5555_5ABC);
    chk("R5 wb at slot5", last_wr_addr, g + 44);
    chk("R6 store sets R and C", last_wr_data, 32'h5555_5183);
    chk("R10 store fill", {31'b0, w_fill}, 1);
  endtask

  task automatic t_secondary_fetch();
    logic [31:0] g1, g2;
    mem.delete();
    g1 = exp_group(VS3, EA_A, 0);
    g2 = exp_group(VS3, EA_A, 1);
    mem[g1] = exp_cmp(VS3, 1, EA_A);
    mem[g1 + 4] = 32'hDEAD_0000;
    mem[g2 + 16] = exp_cmp(VS3, 1, EA_A);
    mem[g2 + 20] = 32'h0F0F_0080;
    walk(EA_A, K_IF, 0);
    chk("R4 H=1 word ignored in primary, hit in secondary", {31'b0, w_fault}, 0);
    chk("R5 reads for secondary slot2", w_reads, 12);
    chk("R7 secondary pa", w_pa, 32'h0F0F_0ABC);
    chk("R6 fetch sets R keeps C", last_wr_data, 32'h0F0F_0180);
    chk("R5 secondary wb addr", last_wr_addr, g2 + 20);
  endtask

  task automatic t_misses();
    mem.delete();
    walk(EA_A, K_IF, 0);
    chk("R9 fetch miss fault", {31'b0, w_fault}, 1);
    chk("R5 miss reads both groups", w_reads, 16);
    chk("R9 next_pc", next_pc, EA_A);
    chk("R9 status untouched", fault_status, 0);
    chk("R10 no fill on miss", {31'b0, w_fill}, 0);
    walk(32'h3000_1004, K_ST, 0);
    chk("R8 store miss status", fault_status, 32'h4200_0000);
    chk("R8 store miss addr", fault_addr, 32'h3000_1004);
    walk(32'h3FFF_F008, K_LD, 0);
    chk("R8 load miss status", fault_status, 32'h4000_0000);
    chk("R8 load miss addr", fault_addr, 32'h3FFF_F008);
    chk("R9 npc kept by data miss", next_pc, EA_A);
  endtask

  task automatic t_debug_and_conly();
    logic [31:0] g;
    mem.delete();
    g = exp_group(VS3, EA_A, 0);
    mem[g + 8] = exp_cmp(VS3, 0, EA_A);
    mem[g + 12] = 32'h7777_7000;
    walk(EA_A, K_DBG, 0);
    chk("R7 debug hit pa", w_pa, 32'h7777_7ABC);
    chk("R6 debug no write", w_writes, 0);
    chk("R6 debug word unchanged", rd_mem(g + 12), 32'h7777_7000);
    chk("R10 debug no fill", {31'b0, w_fill}, 0);
    walk(EA_A, K_ST, 1);
    chk("R6 conly store wb", last_wr_data, 32'h7777_7180);
    chk("R10 conly no fill", {31'b0, w_fill}, 0);
    mem.delete();
    walk(32'h3111_1000, K_DBG, 0);
    chk("R8 debug miss fault", {31'b0, w_fault}, 1);
    chk("R8 debug miss status kept", fault_status, 32'h4000_0000);
    chk("R8 debug miss addr kept", fault_addr, 32'h3FFF_F008);
  endtask

  task automatic t_segment();
    logic [31:0] g, ea;
    mem.delete();
    ea = 32'hB00D_5123;
    g = exp_group(VSB, ea, 0);
    mem[g] = exp_cmp(VSB, 0, ea);
    mem[g + 4] = 32'h0123_4000;
    walk(ea, K_LD, 0);
    chk("R3 segment B group", w_first, g);
    chk("R3 segment B pa", w_pa, 32'h0123_4123);
  endtask

  task automatic t_base_cfg();
    mem.delete();
    set_base(32'h0003_0001);
    set_base(32'h0000_0005);
    walk(EA_A, K_LD, 0);
    chk("R1 rejected writes keep base", w_first, exp_group(VS3, EA_A, 0));
    set_base(32'h0004_0003);
    m_base = 32'h0004_0000; m_hmask = 32'h0000_0FFF;
    walk(EA_A, K_LD, 0);
    chk("R2 two-bit mask group", w_first, exp_group(VS3, EA_A, 0));
    set_base(32'h0200_01FF);
    m_base = 32'h0200_0000; m_hmask = 32'h0007_FFFF;
    walk(EA_A, K_LD, 0);
    chk("R2 nine-bit mask group", w_first, exp_group(VS3, EA_A, 0));
  endtask

  initial begin
    m_base = 32'h0001_0000; m_hmask = 32'h0000_03FF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    set_base(32'h0001_0000);
    set_seg(4'h3, {8'hFF, VS3});
    set_seg(4'hB, {8'h00, VSB});
    t_primary_load();
    t_store_slot5();
    t_secondary_fetch();
    t_misses();
    t_debug_and_conly();
    t_segment();
    t_base_cfg();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule